// File: doc/BRIEF.md
# Sequential Radix-2 Booth Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits and returns their full `2*WIDTH`-bit product. It works over several clock cycles with one shared register: the lower half starts out holding the multiplier and the upper half collects partial sums. A single extra flop keeps the bit most recently shifted out of that register.

On each iteration the block looks at the register's least-significant bit and at the stored bit. From that pair it adds the multiplicand to the upper half, subtracts it, or leaves the upper half alone. It then shifts the whole register one place to the right and copies the sign into the vacated top bit.

A caller pulses `start` while the block is idle. `busy` then stays high for exactly `WIDTH` cycles. `done` pulses once, and `product` holds the result until the next accepted start. The add and subtract use one guard bit, so the most-negative operand values give correct results.

Top module: `booth_seq_mult`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy` is 0, `done` is 0 and `product` is 0.
- R2: A `start` seen at a clock edge while `busy` is 0 captures both operands, sets `busy` to 1 from the next cycle, clears the upper half of the register and loads the multiplier into the lower half. `busy` then stays high for exactly `WIDTH` cycles.
- R3: `done` is 1 for exactly one cycle, the cycle right after the last of the `WIDTH` iterations, and `busy` is 0 in that cycle.
- R4: When `done` is 1, `product` equals the signed product of the captured operands as a `2*WIDTH`-bit two's-complement value.
- R5: The bit pair (current LSB, previous bit) selects the operation. 10 subtracts the multiplicand from the upper half, 01 adds it, and 00 or 11 does no arithmetic. Every iteration ends with an arithmetic right shift by one.
- R6: The most-negative value on either operand, or on both, still gives the exact product. For example, (-2^(W-1))·(-2^(W-1)) = +2^(2W-2).
- R7: A `start` seen while `busy` is 1 is ignored. The running operation finishes with its original operands and on its original schedule.
- R8: While `busy` is 0, `product` keeps its value until a `start` is accepted. A `start` in the `done` cycle itself is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a multiply; honoured only while idle |
| mcand | input | WIDTH | Signed multiplicand |
| mplier | input | WIDTH | Signed multiplier |
| busy | output | 1 | High while iterations are running |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | 2*WIDTH | Product register contents |

## Verification
The bench builds the block with `WIDTH` = 6. At that width the whole operand space of 4096 pairs can be swept, so every run pattern of bits in the multiplier is exercised, along with every sign combination and both most-negative corner cases. A behavioural model predicts `busy`, `done` and `product` on every clock. Directed runs add extra `start` pulses in the middle of an operation and starts issued in the `done` cycle itself.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'b00,
    OP_ADD  = 2'b01,
    OP_SUB  = 2'b10
  } booth_op_e;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic      cur_bit,
  input  logic      prev_bit,
  output booth_op_e op
);
  // R5: pair (cur,prev): 10 -> subtract, 01 -> add, 00/11 -> nothing
  always_comb begin
    unique case ({cur_bit, prev_bit})
      2'b10:   op = OP_SUB;
      2'b01:   op = OP_ADD;
      default: op = OP_HOLD;
    endcase
  end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] acc,
  input  logic [WIDTH-1:0] mcand,
  input  booth_op_e        op,
  output logic [WIDTH:0]   sum
);
  localparam int EXT_W = WIDTH + 1;

  logic [EXT_W-1:0] acc_x;
  logic [EXT_W-1:0] mc_x;

  assign acc_x = {acc[WIDTH-1], acc};
  assign mc_x  = {mcand[WIDTH-1], mcand};

  always_comb begin
    unique case (op)
      OP_ADD:  sum = acc_x + mc_x;
      OP_SUB:  sum = acc_x - mc_x;
      default: sum = acc_x;
    endcase
  end
endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl #(
  parameter int ITERS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (ITERS > 1) ? $clog2(ITERS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ITERS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic             last;

  assign load = start & ~busy_q;
  assign step = busy_q;
  assign last = (cnt_q == LAST);

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        cnt_d  = '0;
      end
    end else if (load) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  p_run_length_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));
  p_finish_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && last) |=> (done_q && !busy_q));
endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
  import booth_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [WIDTH-1:0]     mcand,
  input  logic [WIDTH-1:0]     mplier,
  output logic                 busy,
  output logic                 done,
  output logic [2*WIDTH-1:0]   product
);
  localparam int PW = 2 * WIDTH;

  logic [PW-1:0]    prod_q, prod_d;
  logic             prev_q, prev_d;
  logic [WIDTH-1:0] mc_q;
  logic             load, step, reg_en;
  booth_op_e        op;
  logic [WIDTH:0]   sum;

  booth_seq_ctrl #(.ITERS(WIDTH)) u_ctrl (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .load (load),
    .step (step),
    .busy (busy),
    .done (done)
  );

  booth_recode u_recode (
    .cur_bit (prod_q[0]),
    .prev_bit(prev_q),
    .op      (op)
  );

  booth_addsub #(.WIDTH(WIDTH)) u_addsub (
    .acc  (prod_q[PW-1:WIDTH]),
    .mcand(mc_q),
    .op   (op),
    .sum  (sum)
  );

  assign reg_en = load | step;

  // Arithmetic shift of the (WIDTH+1)-bit sum joined with the lower half.
  always_comb begin
    prod_d = prod_q;
    prev_d = prev_q;
    if (load) begin
      prod_d = {{WIDTH{1'b0}}, mplier};
      prev_d = 1'b0;
    end else if (step) begin
      prod_d = {sum, prod_q[WIDTH-1:1]};
      prev_d = prod_q[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      prev_q <= 1'b0;
    end else if (reg_en) begin
      prod_q <= prod_d;
      prev_q <= prev_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_q <= '0;
    end else if (load) begin
      mc_q <= mcand;
    end
  end

  assign product = prod_q;

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && product == {{WIDTH{1'b0}}, $past(mplier)}));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));
  p_quiet_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (product[0] == prev_q)) |=>
      (product == PW'($signed($past(product)) >>> 1)));
  p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(mc_q));
endmodule

// File: tb/booth_seq_mult_test.sv
`timescale 1ns/1ps
module booth_seq_mult_test;
  localparam int N  = 6;
  localparam int PW = 2 * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [N-1:0]  mcand = '0;
  logic [N-1:0]  mplier = '0;
  logic          busy, done;
  logic [PW-1:0] product;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    finished = 1'b0;
  string cur_req = "R4";

  // reference model state
  bit            m_busy = 1'b0;
  bit            m_done = 1'b0;
  int            m_cnt = 0;
  logic [N-1:0]  m_a = '0, m_b = '0;
  logic [PW-1:0] m_prod = '0;

  booth_seq_mult #(.WIDTH(N)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand),
    .mplier(mplier), .busy(busy), .done(done), .product(product)
  );

  always #4 clk = ~clk;

  function automatic logic [PW-1:0] ref_mul(logic [N-1:0] a, logic [N-1:0] b);
    int ia, ib;
    ia = $signed(a);
    ib = $signed(b);
    return PW'(ia * ib);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_done <= 1'b0; m_cnt <= 0; m_prod <= '0;
    end else begin
      m_done <= 1'b0;
      if (m_busy) begin
        m_cnt <= m_cnt + 1;
        if (m_cnt == N - 1) begin
          m_busy <= 1'b0;
          m_done <= 1'b1;
          m_prod <= ref_mul(m_a, m_b);
        end
      end else if (start) begin
        m_busy <= 1'b1;
        m_cnt  <= 0;
        m_a    <= mcand;
        m_b    <= mplier;
      end
    end
  end

  task automatic check(string req, string what, logic [PW-1:0] got, logic [PW-1:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %h expected %h", req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R2", "busy", PW'(busy), PW'(m_busy));
      check("R3", "done", PW'(done), PW'(m_done));
      if (!m_busy)
        check(m_done ? cur_req : "R8", "product", product, m_prod);
    end
  end

  task automatic mul(logic [N-1:0] a, logic [N-1:0] b, bit noisy, int gap);
    start = 1'b1; mcand = a; mplier = b;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (noisy && i == 1) begin
        start = 1'b1; mcand = ~a; mplier = b ^ 6'h15;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    mcand = $urandom; mplier = $urandom;
    repeat (gap) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", PW'(busy), '0);
    check("R1", "done in reset", PW'(done), '0);
    check("R1", "product in reset", product, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "product after reset", product, '0);
    cur_req = "R4"; mul(6'd3, 6'd5, 1'b0, 2);
    mul(6'h3d, 6'd5, 1'b0, 1);            // -3 * 5
    mul(6'd7, 6'h3f, 1'b0, 3);            // 7 * -1
    cur_req = "R5"; mul(6'h15, 6'h2a, 1'b0, 1);  // alternating runs
    mul(6'h1f, 6'h1e, 1'b0, 1);           // long run of ones
    cur_req = "R6"; mul(6'h20, 6'h20, 1'b0, 1);  // -32 * -32
    mul(6'h20, 6'h1f, 1'b0, 1);
    mul(6'h1f, 6'h20, 1'b0, 1);
    cur_req = "R7"; mul(6'd9, 6'h3a, 1'b1, 1);
    mul(6'h22, 6'd13, 1'b1, 0);
    cur_req = "R8"; mul(6'd11, 6'd2, 1'b0, 0);   // start in done cycle
    mul(6'h30, 6'd4, 1'b0, 5);
    cur_req = "R4";
    for (int a = 0; a < (1 << N); a++)
      for (int b = 0; b < (1 << N); b++)
        mul(N'(a), N'(b), (a + b) % 7 == 0, (a ^ b) & 1);
    repeat (3) @(negedge clk);
    summary();
  end
endmodule